// File: doc/BRIEF.md
# Legacy Interrupt Virtual-Wire Message Generator

This block sits on the upstream side of a bridge to a conventional parallel bus. Downstream devices signal level interrupts on one of four pins (A to D). Each assert or deassert arrives as a request that carries a device number and a pin. The block turns those requests into virtual-wire assert and deassert message codes for the upstream link. The pin is rotated by the device number to choose one of four virtual lines. A per-line device bitmap aggregates the requests. An assert message goes out only when the first device raises a line. A deassert message goes out only when the last device drops it.

Messages wait in a small queue and leave on a valid/ready interface. When the queue is full, the block withholds the request-side ready. Requests are never dropped. The upstream side can refuse a message during its handshake. In that case the block raises a one-cycle error pulse that names the device and pin whose request produced the message.

Top module: `legacy_irq_msg_gen`

## Requirements
- R1: An accepted request maps to virtual line ((device mod 4) + pin) mod 4, with pin encoding 0=A, 1=B, 2=C, 3=D.
- R2: `msg_code` is 3 bits: bit 2 is 1 for an assert message and 0 for a deassert message, and bits 1:0 carry the virtual line index (0..3 for A..D).
- R3: An assert message is queued only when an accepted assertion moves a line's device set from empty to non-empty.
- R4: A deassert message is queued only when an accepted deassertion moves a line's device set from non-empty to empty.
- R5: A repeated assertion by a device already in a line's set, or a deassertion by a device not in it, leaves the set and `line_pending` unchanged and queues nothing.
- R6: `line_pending[i]` is 1 exactly when line i's device set is non-empty; it updates in the cycle after the request is accepted.
- R7: Messages leave in the order they were queued. `msg_valid` and `msg_code` hold steady until `msg_ready` is seen.
- R8: `req_ready` is 0 while the queue holds QDEPTH messages and 1 otherwise; a request is accepted only in a cycle with both `req_valid` and `req_ready` high.
- R9: A handshake with `msg_refuse` high produces `err_valid` for exactly the next cycle, with `err_dev` and `err_pin` from the request that caused that message; there is no pulse otherwise.
- R10: Under synchronous reset all sets are emptied, `line_pending` is 0, the queue is empty (`msg_valid` 0, `req_ready` 1) and `err_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Interrupt request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_assert | input | 1 | 1 = pin asserted, 0 = pin released |
| req_dev | input | DEV_W | Downstream device number |
| req_pin | input | 2 | Interrupt pin, 0..3 = A..D |
| msg_valid | output | 1 | Message code available |
| msg_ready | input | 1 | Upstream takes the message |
| msg_code | output | 3 | {assert flag, line index} |
| msg_refuse | input | 1 | Upstream refuses the message being handed over |
| line_pending | output | 4 | Per-line asserted-upstream state |
| err_valid | output | 1 | One-cycle refusal report |
| err_dev | output | DEV_W | Device number behind the refused message |
| err_pin | output | 2 | Pin behind the refused message |

## Verification
The assertions assume that `msg_refuse` only matters when it coincides with a handshake. They also assume that the request fields are read only in cycles where `req_valid` and `req_ready` are both high. The device number is assumed to stay below NUM_DEV. The stimulus keeps every device number inside 0..31. It holds each request until the ready is observed, and it drives `msg_refuse` freely, because outside a handshake the design must ignore it. Phases with `msg_ready` held low fill the queue so that back-pressure is exercised. Later random phases release `msg_ready` so that the queue drains.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam int NUM_LINES = 4;
  localparam int CODE_W    = 3;

  typedef struct packed {
    logic       is_assert;
    logic [1:0] line;
  } msg_code_t;
endpackage

// File: rtl/lim_line_map.sv
module lim_line_map #(
  parameter int DEV_W = 5
) (
  input  logic [DEV_W-1:0] dev,
  input  logic [1:0]       pin,
  output logic [1:0]       line
);
  logic [1:0] dev_low;
  generate
    if (DEV_W >= 2) begin : g_wide
      assign dev_low = dev[1:0];
    end else begin : g_narrow
      assign dev_low = {1'b0, dev[0]};
    end
  endgenerate
  // modulo 4 comes from the 2-bit sum wrapping
  assign line = dev_low + pin;
endmodule

// File: rtl/lim_pend_tracker.sv
module lim_pend_tracker
  import lim_pkg::*;
#(
  parameter int NUM_DEV = 32,
  parameter int DEV_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_en,
  input  logic [1:0]           upd_line,
  input  logic [DEV_W-1:0]     upd_dev,
  input  logic                 upd_set,
  output logic                 went_busy,
  output logic                 went_idle,
  output logic [NUM_LINES-1:0] pend
);
  logic [NUM_DEV-1:0] bmap_q [NUM_LINES];
  logic [NUM_DEV-1:0] dev_bit, cur_map, nxt_map;

  assign dev_bit = {{(NUM_DEV-1){1'b0}}, 1'b1} << upd_dev;

  always_comb begin
    cur_map   = bmap_q[upd_line];
    nxt_map   = upd_set ? (cur_map | dev_bit) : (cur_map & ~dev_bit);
    went_busy = upd_en && (cur_map == '0) && (nxt_map != '0);
    went_idle = upd_en && (cur_map != '0) && (nxt_map == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LINES; i++) bmap_q[i] <= '0;
      pend <= '0;
    end else if (upd_en) begin
      bmap_q[upd_line] <= nxt_map;
      pend[upd_line]   <= |nxt_map;
    end
  end
endmodule

// File: rtl/lim_msg_fifo.sv
module lim_msg_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/legacy_irq_msg_gen.sv
module legacy_irq_msg_gen
  import lim_pkg::*;
#(
  parameter int NUM_DEV = 32,
  parameter int DEV_W   = 5,
  parameter int QDEPTH  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_assert,
  input  logic [DEV_W-1:0]     req_dev,
  input  logic [1:0]           req_pin,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [CODE_W-1:0]    msg_code,
  input  logic                 msg_refuse,
  output logic [NUM_LINES-1:0] line_pending,
  output logic                 err_valid,
  output logic [DEV_W-1:0]     err_dev,
  output logic [1:0]           err_pin
);
  localparam int ENT_W = DEV_W + 2 + CODE_W;

  logic             accept, went_busy, went_idle, q_push, q_pop, q_empty, q_full;
  logic [1:0]       line;
  msg_code_t        new_code;
  logic [ENT_W-1:0] q_din, q_dout;

  lim_line_map #(.DEV_W(DEV_W)) u_map (
    .dev(req_dev), .pin(req_pin), .line(line)
  );

  assign req_ready = !q_full;
  assign accept    = req_valid && req_ready;

  lim_pend_tracker #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_track (
    .clk(clk), .rst(rst), .upd_en(accept), .upd_line(line), .upd_dev(req_dev),
    .upd_set(req_assert), .went_busy(went_busy), .went_idle(went_idle),
    .pend(line_pending)
  );

  assign new_code = '{is_assert: went_busy, line: line};
  assign q_push   = went_busy || went_idle;
  assign q_din    = {req_dev, req_pin, new_code};

  lim_msg_fifo #(.W(ENT_W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst(rst), .push(q_push), .din(q_din), .pop(q_pop),
    .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  assign msg_valid = !q_empty;
  assign msg_code  = q_dout[CODE_W-1:0];
  assign q_pop     = msg_valid && msg_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid <= 1'b0;
      err_dev   <= '0;
      err_pin   <= '0;
    end else begin
      err_valid <= q_pop && msg_refuse;
      if (q_pop && msg_refuse) begin
        err_dev <= q_dout[ENT_W-1 -: DEV_W];
        err_pin <= q_dout[CODE_W +: 2];
      end
    end
  end
endmodule

// File: rtl/legacy_irq_msg_gen_chk.sv
module legacy_irq_msg_gen_chk #(
  parameter int DEV_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_assert,
  input logic [DEV_W-1:0] req_dev,
  input logic [1:0]       req_pin,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [2:0]       msg_code,
  input logic             msg_refuse,
  input logic [3:0]       line_pending,
  input logic             err_valid
);
  logic [1:0] chk_line;
  assign chk_line = 2'(req_dev) + req_pin;

  a_r6_assert_sets_pending: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_assert) |=> line_pending[$past(chk_line)]);

  a_r7_msg_held: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_code)));

  a_r8_full_has_msg: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> msg_valid);

  a_r9_err_after_refuse: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $past(msg_valid && msg_ready && msg_refuse));

  a_r9_no_spurious_err: assert property (@(posedge clk) disable iff (rst)
    !(msg_valid && msg_ready && msg_refuse) |=> !err_valid);
endmodule

bind legacy_irq_msg_gen legacy_irq_msg_gen_chk #(.DEV_W(DEV_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_assert(req_assert), .req_dev(req_dev), .req_pin(req_pin),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_code(msg_code),
  .msg_refuse(msg_refuse), .line_pending(line_pending), .err_valid(err_valid)
);

// File: tb/tb_legacy_irq_msg_gen.sv
module tb_legacy_irq_msg_gen;
  localparam int DEPTH = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_assert = 0, msg_ready = 0, msg_refuse = 0;
  logic [4:0] req_dev = '0;
  logic [1:0] req_pin = '0;
  logic req_ready, msg_valid, err_valid;
  logic [2:0] msg_code;
  logic [3:0] line_pending;
  logic [4:0] err_dev;
  logic [1:0] err_pin;

  always #2.5 clk = ~clk;

  legacy_irq_msg_gen #(.NUM_DEV(32), .DEV_W(5), .QDEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_assert(req_assert), .req_dev(req_dev), .req_pin(req_pin),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_code(msg_code),
    .msg_refuse(msg_refuse), .line_pending(line_pending), .err_valid(err_valid),
    .err_dev(err_dev), .err_pin(err_pin)
  );

  // reference model
  bit [31:0] bm [4];
  int q_code[$], q_dev[$], q_pin[$];
  int e_err = 0, e_dev = 0, e_pin = 0;
  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_pend();
    int p = 0;
    for (int l = 0; l < 4; l++) if (bm[l] != 0) p |= (1 << l);
    return p;
  endfunction

  task automatic compare();
    chk("R7 msg_valid", int'(msg_valid), int'(q_code.size() > 0));
    if (q_code.size() > 0 && msg_valid)
      chk("R1 R2 R3 R4 R5 R7 msg_code", int'(msg_code), q_code[0]);
    chk("R5 R6 line_pending", int'(line_pending), exp_pend());
    chk("R8 req_ready", int'(req_ready), int'(q_code.size() < DEPTH));
    chk("R9 err_valid", int'(err_valid), e_err);
    if (e_err != 0 && err_valid) begin
      chk("R9 err_dev", int'(err_dev), e_dev);
      chk("R9 err_pin", int'(err_pin), e_pin);
    end
  endtask

  // one cycle: compare at negedge, drive, advance the model
  task automatic step(input bit v, input bit a, input int dev, input int pin,
                      input bit mr, input bit rf, output bit took);
    bit rdy, pop;
    int line, was, now;
    @(negedge clk);
    compare();
    req_valid = v; req_assert = a; req_dev = 5'(dev); req_pin = 2'(pin);
    msg_ready = mr; msg_refuse = rf;
    rdy  = q_code.size() < DEPTH;
    pop  = (q_code.size() > 0) && mr;
    took = v && rdy;
    e_err = int'(pop && rf);
    if (pop) begin
      if (rf) begin e_dev = q_dev[0]; e_pin = q_pin[0]; end
      void'(q_code.pop_front()); void'(q_dev.pop_front()); void'(q_pin.pop_front());
    end
    if (took) begin
      line = ((dev % 4) + pin) % 4;
      was = int'(bm[line] != 0);
      if (a) bm[line][dev] = 1'b1; else bm[line][dev] = 1'b0;
      now = int'(bm[line] != 0);
      if (was != now) begin
        q_code.push_back((now << 2) | line);
        q_dev.push_back(dev);
        q_pin.push_back(pin);
      end
    end
  endtask

  // hold a request until accepted
  task automatic send(input bit a, input int dev, input int pin, input bit mr, input bit rf);
    bit took = 0;
    while (!took) step(1'b1, a, dev, pin, mr, rf, took);
  endtask

  task automatic idle(input int n, input bit mr, input bit rf);
    bit t;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, mr, rf, t);
  endtask

  initial begin : watchdog
    #(5 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    bit t;
    for (int l = 0; l < 4; l++) bm[l] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 msg_valid", int'(msg_valid), 0);
    chk("R10 req_ready", int'(req_ready), 1);
    chk("R10 line_pending", int'(line_pending), 0);
    chk("R10 err_valid", int'(err_valid), 0);
    rst = 0;

    // R1 R3: dev 5 pin A -> line 1 assert
    send(1, 5, 0, 0, 0);
    idle(1, 0, 0);
    chk("R1 R2 assert-B code", int'(msg_code), 3'b101);
    // R3: second device on same line (dev 9 pin A) -> no new message
    send(1, 9, 0, 0, 0);
    // R5: duplicate assertion
    send(1, 5, 0, 0, 0);
    idle(2, 1, 0);
    // R4: first release keeps line, second releases it
    send(0, 5, 0, 1, 0);
    send(0, 9, 0, 1, 0);
    // R5: release from a device that never asserted (dev 2 pin C -> line 0)
    send(0, 2, 2, 1, 0);
    idle(3, 1, 0);

    // R1: rotation sweep
    for (int d = 0; d < 8; d++)
      for (int p = 0; p < 4; p++) begin
        send(1, d, p, 1, 0);
        idle(1, 1, 0);
        send(0, d, p, 1, 0);
      end
    idle(3, 1, 0);

    // R8: fill the queue with upstream stalled, then drain
    for (int l = 0; l < 4; l++) send(1, 8 + l, 0, 0, 0);
    fork
      send(0, 8, 0, 0, 0);
      begin idle(0, 0, 0); end
    join_none
    #1;
    disable fork;
    // queue full: a held release must wait
    for (int i = 0; i < 4; i++) step(1, 0, 8, 0, 0, 0, t);
    chk("R8 ready low while full", int'(req_ready), 0);
    send(0, 8, 0, 1, 0);
    idle(6, 1, 0);

    // R9: refused messages
    send(1, 13, 3, 1, 1);
    idle(2, 1, 1);
    send(0, 13, 3, 1, 1);
    idle(3, 1, 1);
    // R9: refuse without a handshake has no effect
    idle(3, 0, 1);

    // random mix
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 31),
           $urandom_range(0, 3), $urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0, t);
    idle(10, 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule